// File: doc/BRIEF.md
# Registered Address and Command Buffer with Parity Check

This block is a single pipeline stage placed between a memory controller and a rank-pair of memory devices. On each rising clock edge it captures the row/column address, bank select, the three command strobes, the per-rank chip selects, clock enables and termination controls. It presents them to the devices one clock later, so every output is a clean registered copy of what the host drove one cycle before.

The host also sends one parity bit with each command. The block compares that bit with the exclusive-OR of the address, bank and command strobes. A mismatch on a cycle where a rank is selected produces a one-cycle low pulse on an error output. That pulse is aligned with the registered command it belongs to. When neither rank is selected, the address, bank and command outputs are forced low, while chip select, clock enable and termination keep following their inputs.

An active-low reset clears the pipeline at the clock edge. It also forces every device-side output low as soon as it is asserted, without waiting for a clock edge.

Top module: `ca_reg_buffer`

## Requirements
- R1: With at least one chip select low at the sampling edge, address, bank, ras_n, cas_n and we_n appear on the outputs exactly one clock later, unchanged.
- R2: Clock-enable and termination outputs equal their inputs from one clock earlier, whatever the chip selects are.
- R3: The chip-select outputs equal the chip-select inputs from one clock earlier and are never blanked.
- R4: When both chip selects were high at the sampling edge, the address, bank, ras_n, cas_n and we_n outputs are all 0 for that cycle.
- R5: The parity input must equal the XOR of {address, bank, ras_n, cas_n, we_n} (1 when that group holds an odd number of ones). A mismatch sampled while at least one chip select is low drives err_n_o low for exactly the next cycle. A correct parity leaves err_n_o high, and back-to-back bad commands give one low cycle each.
- R6: When both chip selects are high, a parity mismatch does not report an error: err_n_o stays high.
- R7: Chip select, clock enable and termination bits are not part of the parity group; changing them alone never causes an error.
- R8: While rst_n is low, every device-side output is 0 and err_n_o is 1, immediately and without a clock edge. After rst_n rises, the outputs stay 0 until the first edge that samples new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | ADDR_W | Row/column address from host |
| bank_i | input | BANK_W | Bank select from host |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| cs_n_i | input | RANKS | Per-rank chip select, active low |
| cke_i | input | RANKS | Per-rank clock enable |
| odt_i | input | RANKS | Per-rank termination control |
| par_i | input | 1 | Host parity over address, bank and strobes |
| addr_o | output | ADDR_W | Registered address to devices |
| bank_o | output | BANK_W | Registered bank select |
| ras_n_o | output | 1 | Registered row strobe |
| cas_n_o | output | 1 | Registered column strobe |
| we_n_o | output | 1 | Registered write strobe |
| cs_n_o | output | RANKS | Registered chip selects |
| cke_o | output | RANKS | Registered clock enables |
| odt_o | output | RANKS | Registered termination controls |
| err_n_o | output | 1 | Parity error pulse, active low |

## Verification
On every cycle, the embedded properties check several rules. The registered path keeps one-clock fidelity for selected commands and for the clock-enable and termination lines. Deselected cycles show zeros on the address and command outputs. An error pulse always traces back to a selected, mismatched command in the previous cycle. Whenever reset is low, the outputs are held at zero. The bench scenarios cover the remaining behaviour: errors do appear when they should and no spurious pulse follows a good command, chip select, clock enable and termination stay out of the parity group, reset takes effect mid-run, and the cycle right after reset release still shows zeros.

// File: rtl/cab_pkg.sv
// Package: shared default sizes for the registered address/command buffer.
// Assumes a two-rank module with four banks and a 14-bit address.
package cab_pkg;
    parameter int CAB_ADDR_W = 14;
    parameter int CAB_BANK_W = 2;
    parameter int CAB_RANKS  = 2;
    parameter int CAB_STROBES = 3;   // ras_n, cas_n, we_n
endpackage

// File: rtl/cab_pipe_reg.sv
// Module: cab_pipe_reg
// One-clock register of parameterised width with synchronous active-low
// reset to RST_VAL. Assumes the reset is synchronous to clk.
module cab_pipe_reg #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: capture d every edge, load RST_VAL while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/cab_parity_chk.sv
// Module: cab_parity_chk
// Compares the host parity bit with the XOR of the protected group.
// Assumes the host bit equals the group XOR when there is no error.
// Mismatch is reported only when check_en is high.
module cab_parity_chk #(
    parameter int W = 19
) (
    input  logic [W-1:0] grp,
    input  logic         par,
    input  logic         check_en,
    output logic         mismatch
);
    logic calc;

    // Purpose: reduce the group to one parity bit and compare.
    always_comb begin
        calc     = ^grp;
        mismatch = check_en && (calc != par);
    end
endmodule

// File: rtl/cab_out_gate.sv
// Module: cab_out_gate
// Output stage: blanks the command group when no rank is selected and
// forces all device-side lanes low while reset is low. Keeps the error
// flag inactive (high) during reset. Purely combinational.
module cab_out_gate #(
    parameter int CMD_W  = 19,
    parameter int SIDE_W = 6
) (
    input  logic              rst_n,
    input  logic              blank,
    input  logic [CMD_W-1:0]  cmd_q,
    input  logic [SIDE_W-1:0] side_q,
    input  logic              err_q,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [SIDE_W-1:0] side_o,
    output logic              err_o
);
    // Purpose: zero the command group on reset or deselect.
    always_comb begin
        cmd_o = (rst_n && !blank) ? cmd_q : '0;
        err_o = rst_n ? err_q : 1'b1;
    end

    // Per-lane gating of select, clock-enable and termination lines.
    for (genvar g = 0; g < SIDE_W; g++) begin : g_side
        assign side_o[g] = rst_n & side_q[g];
    end

    // Purpose: reset must hold every device lane low without a clock edge.
    always_comb begin
        if (!rst_n) begin
            a_r8_reset_low: assert (cmd_o == '0 && side_o == '0 && err_o == 1'b1)
                else $error("a_r8_reset_low");
        end
    end
endmodule

// File: rtl/ca_reg_buffer.sv
// Module: ca_reg_buffer
// Registered address/command buffer with host-parity check.
// Assumes: synchronous active-low reset (outputs also gated immediately),
// active-low chip selects, one parity bit per command cycle.
module ca_reg_buffer
    import cab_pkg::*;
#(
    parameter int ADDR_W = CAB_ADDR_W,
    parameter int BANK_W = CAB_BANK_W,
    parameter int RANKS  = CAB_RANKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [RANKS-1:0]  cs_n_i,
    input  logic [RANKS-1:0]  cke_i,
    input  logic [RANKS-1:0]  odt_i,
    input  logic              par_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [RANKS-1:0]  cs_n_o,
    output logic [RANKS-1:0]  cke_o,
    output logic [RANKS-1:0]  odt_o,
    output logic              err_n_o
);
    localparam int GRP_W  = ADDR_W + BANK_W + CAB_STROBES;
    localparam int SIDE_W = 3 * RANKS;

    logic [GRP_W-1:0]  grp_d, cmd_q, cmd_g;
    logic [SIDE_W-1:0] side_d, side_q, side_g;
    logic              any_sel, mismatch, err_q, blank_q;

    // Purpose: assemble the protected group and the side-band lanes.
    always_comb begin
        grp_d   = {addr_i, bank_i, ras_n_i, cas_n_i, we_n_i};
        side_d  = {odt_i, cke_i, cs_n_i};
        any_sel = ~&cs_n_i;
    end

    cab_parity_chk #(.W(GRP_W)) u_par (
        .grp      (grp_d),
        .par      (par_i),
        .check_en (any_sel),
        .mismatch (mismatch)
    );

    cab_pipe_reg #(.W(GRP_W), .RST_VAL('0)) u_cmd_reg (
        .clk (clk), .rst_n (rst_n), .d (grp_d), .q (cmd_q)
    );

    cab_pipe_reg #(.W(SIDE_W), .RST_VAL('0)) u_side_reg (
        .clk (clk), .rst_n (rst_n), .d (side_d), .q (side_q)
    );

    cab_pipe_reg #(.W(1), .RST_VAL(1'b1)) u_err_reg (
        .clk (clk), .rst_n (rst_n), .d (~mismatch), .q (err_q)
    );

    // Purpose: blank the command group when both registered selects are high.
    always_comb blank_q = &side_q[RANKS-1:0];

    cab_out_gate #(.CMD_W(GRP_W), .SIDE_W(SIDE_W)) u_gate (
        .rst_n  (rst_n),
        .blank  (blank_q),
        .cmd_q  (cmd_q),
        .side_q (side_q),
        .err_q  (err_q),
        .cmd_o  (cmd_g),
        .side_o (side_g),
        .err_o  (err_n_o)
    );

    // Purpose: split gated vectors back onto named ports.
    always_comb begin
        {addr_o, bank_o, ras_n_o, cas_n_o, we_n_o} = cmd_g;
        {odt_o, cke_o, cs_n_o}                     = side_g;
    end

    // ---------------- assertions ----------------
    logic armed;
    // Purpose: mark that one non-reset edge has filled the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_cmd_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !(&$past(cs_n_i))) |->
        ({addr_o, bank_o, ras_n_o, cas_n_o, we_n_o} ==
         $past({addr_i, bank_i, ras_n_i, cas_n_i, we_n_i})))
        else $error("a_r1_cmd_latency");

    a_r2_side_latency: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cke_o == $past(cke_i) && odt_o == $past(odt_i)
                   && cs_n_o == $past(cs_n_i)))
        else $error("a_r2_side_latency");

    a_r4_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && &cs_n_o) |->
        (addr_o == '0 && bank_o == '0 && !ras_n_o && !cas_n_o && !we_n_o))
        else $error("a_r4_blank");

    a_r5_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !err_n_o) |->
        (!(&$past(cs_n_i)) &&
         ((^$past({addr_i, bank_i, ras_n_i, cas_n_i, we_n_i})) != $past(par_i))))
        else $error("a_r5_err_source");
endmodule

// File: tb/ca_reg_buffer_bench.sv
`timescale 1ns/1ps
module ca_reg_buffer_bench;
    localparam int AW = 14;
    localparam int BW = 2;
    localparam int RK = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic [BW-1:0] bank_i;
    logic          ras_n_i, cas_n_i, we_n_i, par_i;
    logic [RK-1:0] cs_n_i, cke_i, odt_i;
    logic [AW-1:0] addr_o;
    logic [BW-1:0] bank_o;
    logic          ras_n_o, cas_n_o, we_n_o, err_n_o;
    logic [RK-1:0] cs_n_o, cke_o, odt_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [BW-1:0] bank;
        logic [2:0]    strb;
        logic [RK-1:0] cs, cke, odt;
        logic          err_n;
        string         ctag;
        string         etag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;   // 200 MHz

    ca_reg_buffer u_ca_reg_buffer (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .bank_i(bank_i),
        .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i),
        .cs_n_i(cs_n_i), .cke_i(cke_i), .odt_i(odt_i), .par_i(par_i),
        .addr_o(addr_o), .bank_o(bank_o), .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o), .we_n_o(we_n_o), .cs_n_o(cs_n_o),
        .cke_o(cke_o), .odt_o(odt_o), .err_n_o(err_n_o)
    );

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // Driver: apply one command at the falling edge and queue its expectation.
    task automatic drive(logic [AW-1:0] a, logic [BW-1:0] b, logic [2:0] s,
                         logic [RK-1:0] cs, logic [RK-1:0] ck, logic [RK-1:0] od,
                         bit bad_par, string etag);
        exp_t e;
        logic good;
        @(negedge clk);
        addr_i = a; bank_i = b; {ras_n_i, cas_n_i, we_n_i} = s;
        cs_n_i = cs; cke_i = ck; odt_i = od;
        good  = ^{a, b, s};
        par_i = bad_par ? ~good : good;
        e.addr  = (&cs) ? '0 : a;
        e.bank  = (&cs) ? '0 : b;
        e.strb  = (&cs) ? 3'b000 : s;
        e.cs = cs; e.cke = ck; e.odt = od;
        e.err_n = !(bad_par && !(&cs));
        e.ctag  = (&cs) ? "R4" : "R1";
        e.etag  = etag;
        sb.push_back(e);
    endtask

    // Monitor: compare registered outputs just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n === 1'b1 && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.ctag, "addr", 32'(addr_o), 32'(e.addr));
            check(e.ctag, "bank", 32'(bank_o), 32'(e.bank));
            check(e.ctag, "strobes", 32'({ras_n_o, cas_n_o, we_n_o}), 32'(e.strb));
            check("R3", "cs_n", 32'(cs_n_o), 32'(e.cs));
            check("R2", "cke", 32'(cke_o), 32'(e.cke));
            check("R2", "odt", 32'(odt_o), 32'(e.odt));
            check(e.etag, "err_n", 32'(err_n_o), 32'(e.err_n));
        end
    end

    task automatic check_reset_zero(string what);
        check("R8", {what, " addr"}, 32'(addr_o), 0);
        check("R8", {what, " side"}, 32'({cs_n_o, cke_o, odt_o}), 0);
        check("R8", {what, " strobes"}, 32'({ras_n_o, cas_n_o, we_n_o, bank_o}), 0);
        check("R8", {what, " err_n"}, 32'(err_n_o), 1);
    endtask

    task automatic flush();
        @(posedge clk); #2;
    endtask

    initial begin
        rst_n = 1'b0;
        addr_i = '1; bank_i = '1; {ras_n_i, cas_n_i, we_n_i} = 3'b111;
        cs_n_i = 2'b01; cke_i = '1; odt_i = '1; par_i = 1'b0;
        repeat (3) @(posedge clk);
        #1 check_reset_zero("in reset");
        @(negedge clk); rst_n = 1'b1;
        #0.5 check_reset_zero("after release");

        // R1/R5: selected commands with good parity.
        drive(14'h1A5C, 2'd2, 3'b011, 2'b10, 2'b11, 2'b01, 0, "R5");
        drive(14'h0001, 2'd1, 3'b101, 2'b01, 2'b11, 2'b00, 0, "R5");
        drive(14'h3FFF, 2'd3, 3'b110, 2'b00, 2'b10, 2'b11, 0, "R5");
        // R5: bad parity, then back-to-back bad, then good.
        drive(14'h0F0F, 2'd0, 3'b001, 2'b10, 2'b11, 2'b00, 1, "R5");
        drive(14'h2222, 2'd1, 3'b010, 2'b01, 2'b11, 2'b00, 1, "R5");
        drive(14'h2223, 2'd1, 3'b010, 2'b01, 2'b11, 2'b00, 1, "R5");
        drive(14'h2224, 2'd1, 3'b010, 2'b01, 2'b11, 2'b00, 0, "R5");
        // R4/R6: deselected, bad parity ignored, outputs blanked.
        drive(14'h1357, 2'd3, 3'b111, 2'b11, 2'b01, 2'b10, 1, "R6");
        drive(14'h2468, 2'd2, 3'b000, 2'b11, 2'b00, 2'b11, 0, "R6");
        // R7: only cs/cke/odt toggle; parity over the group alone stays good.
        for (int k = 0; k < 8; k++)
            drive(14'h0ABC, 2'd1, 3'b011, 2'(k & 1 ? 2'b01 : 2'b10), 2'(k), 2'(k >> 1), 0, "R7");
        // Mixed patterns.
        for (int i = 0; i < 60; i++) begin
            logic [RK-1:0] cs;
            cs = 2'($urandom_range(0, 3));
            drive(14'($urandom), 2'($urandom), 3'($urandom), cs,
                  2'($urandom), 2'($urandom), bit'(i % 3 == 0),
                  (&cs) ? "R6" : "R5");
        end
        flush();

        // R8: reset mid-run forces outputs low before any edge.
        drive(14'h3AAA, 2'd3, 3'b111, 2'b10, 2'b11, 2'b11, 1, "R5");
        flush();
        @(negedge clk); rst_n = 1'b0;
        #0.5 check_reset_zero("mid-run");
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5 check_reset_zero("second release");
        drive(14'h0055, 2'd2, 3'b100, 2'b01, 2'b01, 2'b10, 0, "R5");
        flush();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule